// File: doc/BRIEF.md
# Standby Mode Entry/Release Controller

This block governs the low-power standby state of a small processor. Software asks for standby by writing a control word whose request bit is set. A second bit in the same word picks light standby or deep standby. The controller accepts the request only when no enabled interrupt is pending and no watchdog interrupt has just arrived. When it accepts, it stops the CPU clock and, for deep standby, gates every peripheral clock except the one for the time-base timer.

Standby ends when any interrupt latch whose own enable bit is set reads 1. At that point the control bit clears itself, the block returns to run mode, and a one-cycle resume strobe is issued. A flag travels with the strobe. The flag tells the CPU whether to service the waking interrupt before it continues at the next instruction, and it takes its value from the master interrupt enable.

A system reset request (pin, power-on or voltage-detect) overrides everything and moves the block into warm-up. The block leaves warm-up for run mode once the external warm-up counter reports done.

Top module: `standby_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any cycle with `sys_reset_req` high, the block is in warm-up, whatever the other inputs do. In warm-up: `standby_active`=0, `standby_deep`=0, `standby_bit`=0, `run_ready`=0, `cpu_clk_en`=0, `resume_pulse`=0, and `periph_clk_en` has only bit `TBT_BIT` set.
- R2: In warm-up, `warmup_done`=1 at a clock edge (with no reset request) puts the block in run mode from the next cycle. In run mode `run_ready`=1, `cpu_clk_en`=1 and every `periph_clk_en` bit is 1.
- R3: In run mode, a `ctrl_wr` with `ctrl_wdata[0]`=1 that is accepted puts the block in standby from the next cycle. Then `standby_bit`=1, `standby_active`=1, `run_ready`=0, `cpu_clk_en`=0, and `standby_deep` equals `ctrl_wdata[1]`.
- R4: The write is refused, and `standby_bit` stays 0, if any bit of `int_latch & int_enable` is 1 in the cycle of the write.
- R5: The write is refused if `wdt_irq` is 1 in the cycle of the write, or was 1 in any of the `WDT_GUARD` preceding cycles.
- R6: In standby, any bit of `int_latch & int_enable` at 1 releases standby at the next edge. Latch bits whose enable is 0 have no effect.
- R7: On release, `standby_bit` clears without any write, and run mode outputs (`run_ready`, `cpu_clk_en`, all peripheral clocks) return from the next cycle.
- R8: `resume_pulse` is high for exactly the one cycle after the release edge. `resume_service` then equals the `master_ie` value sampled at that edge: 1 means service the interrupt first, 0 means resume directly.
- R9: In light standby (`ctrl_wdata[1]`=0) every `periph_clk_en` bit stays 1. In deep standby (`ctrl_wdata[1]`=1) only bit `TBT_BIT` is 1.
- R10: A `ctrl_wr` with `ctrl_wdata[0]`=0 leaves the block in run mode, with `standby_bit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_reset_req | input | 1 | Pin, power-on or voltage-detect reset request |
| warmup_done | input | 1 | External warm-up counter has expired |
| ctrl_wr | input | 1 | Write strobe for the standby control word |
| ctrl_wdata | input | 2 | bit0 request standby, bit1 select deep variant |
| int_latch | input | SRC_W | Interrupt latch vector |
| int_enable | input | SRC_W | Per-source interrupt enable vector |
| master_ie | input | 1 | Master interrupt enable |
| wdt_irq | input | 1 | Watchdog interrupt pulse |
| standby_bit | output | 1 | Standby control bit as software reads it |
| standby_active | output | 1 | Block is in light or deep standby |
| standby_deep | output | 1 | Block is in deep standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | PERIPH_W | Peripheral clock enables |
| resume_pulse | output | 1 | One-cycle strobe on wake-up |
| resume_service | output | 1 | With the strobe: 1 service interrupt first |
| run_ready | output | 1 | Run mode active (warm-up complete) |

## Verification
If the state register held a wrong value, the clock enables would show it in the very next cycle. A stuck standby state keeps `cpu_clk_en` low, and a false deep state drops the non-timer peripheral clocks. A bad refusal check shows one cycle after the write, through `standby_bit`. A wrong watchdog guard count lets a write through at the wrong distance from the pulse. A wrong release path shows in the cycle after the latch rises: the resume strobe is missing or stretched, or its service flag is wrong.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_WARM  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LIGHT = 2'd2,
    ST_DEEP  = 2'd3
  } stby_state_e;

  typedef struct packed {
    logic deep;
    logic req;
  } ctrl_word_t;
endpackage

// File: rtl/stby_rst_sync.sv
module stby_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/stby_wake_detect.sv
module stby_wake_detect #(
  parameter int SRC_W = 8
) (
  input  logic [SRC_W-1:0] int_latch,
  input  logic [SRC_W-1:0] int_enable,
  output logic             wake
);
  logic [SRC_W-1:0] armed;

  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    assign armed[i] = int_latch[i] & int_enable[i];
  end

  assign wake = |armed;
endmodule

// File: rtl/stby_wdt_guard.sv
module stby_wdt_guard #(
  parameter int GUARD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_irq,
  output logic block
);
  localparam int CW = $clog2(GUARD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = wdt_irq || (cnt_q != '0);
    if (wdt_irq) cnt_d = CW'(GUARD);
    else         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign block = wdt_irq || (cnt_q != '0);
endmodule

// File: rtl/stby_clk_map.sv
module stby_clk_map
  import stby_pkg::*;
#(
  parameter int PERIPH_W = 6,
  parameter int TBT_BIT  = 0
) (
  input  stby_state_e         state,
  output logic [PERIPH_W-1:0] periph_clk_en,
  output logic                cpu_clk_en
);
  logic gate_others;

  assign gate_others = (state == ST_DEEP) || (state == ST_WARM);
  assign cpu_clk_en  = (state == ST_RUN);

  for (genvar i = 0; i < PERIPH_W; i++) begin : g_clk
    if (i == TBT_BIT) begin : g_tbt
      assign periph_clk_en[i] = 1'b1;
    end else begin : g_other
      assign periph_clk_en[i] = !gate_others;
    end
  end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sys_reset_req,
  input  logic        warmup_done,
  input  logic        ctrl_wr,
  input  ctrl_word_t  ctrl_wdata,
  input  logic        wake,
  input  logic        wdt_block,
  input  logic        master_ie,
  output stby_state_e state,
  output logic        resume_pulse,
  output logic        resume_service
);
  stby_state_e state_q, state_d;
  logic        pulse_q, pulse_d;
  logic        svc_q, svc_d;
  logic        accept;

  assign accept = ctrl_wr && ctrl_wdata.req && !wake && !wdt_block;

  always_comb begin
    state_d = state_q;
    pulse_d = 1'b0;
    svc_d   = svc_q;
    unique case (state_q)
      ST_WARM:  if (warmup_done) state_d = ST_RUN;
      ST_RUN:   if (accept) state_d = ctrl_wdata.deep ? ST_DEEP : ST_LIGHT;
      ST_LIGHT, ST_DEEP: begin
        if (wake) begin
          state_d = ST_RUN;
          pulse_d = 1'b1;
          svc_d   = master_ie;
        end
      end
      default:  state_d = ST_WARM;
    endcase
    if (sys_reset_req) begin
      state_d = ST_WARM;
      pulse_d = 1'b0;
      svc_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WARM;
      pulse_q <= 1'b0;
      svc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      svc_q   <= svc_d;
    end
  end

  assign state          = state_q;
  assign resume_pulse   = pulse_q;
  assign resume_service = svc_q;
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import stby_pkg::*;
#(
  parameter int SRC_W     = 8,
  parameter int PERIPH_W  = 6,
  parameter int TBT_BIT   = 0,
  parameter int WDT_GUARD = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sys_reset_req,
  input  logic                warmup_done,
  input  logic                ctrl_wr,
  input  logic [1:0]          ctrl_wdata,
  input  logic [SRC_W-1:0]    int_latch,
  input  logic [SRC_W-1:0]    int_enable,
  input  logic                master_ie,
  input  logic                wdt_irq,
  output logic                standby_bit,
  output logic                standby_active,
  output logic                standby_deep,
  output logic                cpu_clk_en,
  output logic [PERIPH_W-1:0] periph_clk_en,
  output logic                resume_pulse,
  output logic                resume_service,
  output logic                run_ready
);
  logic        rst_n_s;
  logic        wake;
  logic        wdt_block;
  stby_state_e state;
  ctrl_word_t  wword;

  assign wword = ctrl_word_t'(ctrl_wdata);

  stby_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  stby_wake_detect #(.SRC_W(SRC_W)) u_wake (
    .int_latch(int_latch), .int_enable(int_enable), .wake(wake)
  );

  stby_wdt_guard #(.GUARD(WDT_GUARD)) u_guard (
    .clk(clk), .rst_n(rst_n_s), .wdt_irq(wdt_irq), .block(wdt_block)
  );

  stby_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .sys_reset_req(sys_reset_req),
    .warmup_done(warmup_done), .ctrl_wr(ctrl_wr), .ctrl_wdata(wword),
    .wake(wake), .wdt_block(wdt_block), .master_ie(master_ie),
    .state(state), .resume_pulse(resume_pulse),
    .resume_service(resume_service)
  );

  stby_clk_map #(.PERIPH_W(PERIPH_W), .TBT_BIT(TBT_BIT)) u_clk (
    .state(state), .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en)
  );

  assign standby_active = (state == ST_LIGHT) || (state == ST_DEEP);
  assign standby_deep   = (state == ST_DEEP);
  assign standby_bit    = standby_active;
  assign run_ready      = (state == ST_RUN);
endmodule

// File: rtl/standby_ctrl_checker.sv
module standby_ctrl_checker #(
  parameter int SRC_W    = 8,
  parameter int PERIPH_W = 6,
  parameter int TBT_BIT  = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sys_reset_req,
  input logic                ctrl_wr,
  input logic [1:0]          ctrl_wdata,
  input logic [SRC_W-1:0]    int_latch,
  input logic [SRC_W-1:0]    int_enable,
  input logic                master_ie,
  input logic                wdt_irq,
  input logic                standby_bit,
  input logic                standby_active,
  input logic                standby_deep,
  input logic                cpu_clk_en,
  input logic [PERIPH_W-1:0] periph_clk_en,
  input logic                resume_pulse,
  input logic                resume_service,
  input logic                run_ready
);
  localparam logic [PERIPH_W-1:0] TBT_MASK = PERIPH_W'(1) << TBT_BIT;

  logic pend;
  assign pend = |(int_latch & int_enable);

  assert_reset_warm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> (!standby_active && !run_ready && !resume_pulse));

  assert_refuse_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ready && ctrl_wr && ctrl_wdata[0] && pend) |=> !standby_bit);

  assert_refuse_wdt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ready && ctrl_wr && wdt_irq) |=> !standby_bit);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_active && pend && !sys_reset_req) |=> (!standby_active && resume_pulse));

  assert_restore_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_active && pend && !sys_reset_req) |=> (run_ready && cpu_clk_en && !standby_bit));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  assert_service_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_active && pend && !sys_reset_req) |=> (resume_service == $past(master_ie)));

  assert_deep_gating_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby_deep |-> (periph_clk_en == TBT_MASK));
endmodule

bind standby_ctrl standby_ctrl_checker #(
  .SRC_W(SRC_W), .PERIPH_W(PERIPH_W), .TBT_BIT(TBT_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_reset_req(sys_reset_req),
  .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .int_latch(int_latch),
  .int_enable(int_enable), .master_ie(master_ie), .wdt_irq(wdt_irq),
  .standby_bit(standby_bit), .standby_active(standby_active),
  .standby_deep(standby_deep), .cpu_clk_en(cpu_clk_en),
  .periph_clk_en(periph_clk_en), .resume_pulse(resume_pulse),
  .resume_service(resume_service), .run_ready(run_ready)
);

// File: tb/standby_ctrl_bench.sv
`timescale 1ns/1ps
module standby_ctrl_bench;
  localparam int SRC_W = 8, PERIPH_W = 6, TBT_BIT = 0, WDT_GUARD = 4;
  localparam logic [PERIPH_W-1:0] ALL_ON = '1;
  localparam logic [PERIPH_W-1:0] TBT_ONLY = PERIPH_W'(1) << TBT_BIT;

  logic clk = 1'b0;
  logic rst_n, sys_reset_req, warmup_done, ctrl_wr, master_ie, wdt_irq;
  logic [1:0] ctrl_wdata;
  logic [SRC_W-1:0] int_latch, int_enable;
  logic standby_bit, standby_active, standby_deep, cpu_clk_en;
  logic [PERIPH_W-1:0] periph_clk_en;
  logic resume_pulse, resume_service, run_ready;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  standby_ctrl #(.SRC_W(SRC_W), .PERIPH_W(PERIPH_W), .TBT_BIT(TBT_BIT),
                 .WDT_GUARD(WDT_GUARD)) u_standby_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_reset_req(sys_reset_req),
    .warmup_done(warmup_done), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .int_latch(int_latch), .int_enable(int_enable), .master_ie(master_ie),
    .wdt_irq(wdt_irq), .standby_bit(standby_bit),
    .standby_active(standby_active), .standby_deep(standby_deep),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .resume_pulse(resume_pulse), .resume_service(resume_service),
    .run_ready(run_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [1:0] w);
    ctrl_wr = 1'b1; ctrl_wdata = w;
    step(1);
    ctrl_wr = 1'b0; ctrl_wdata = 2'b00;
  endtask

  task automatic test_reset_R1();
    rst_n = 1'b0; sys_reset_req = 0; warmup_done = 1; ctrl_wr = 1;
    ctrl_wdata = 2'b01; int_latch = '0; int_enable = '0; master_ie = 0; wdt_irq = 0;
    step(3);
    check("R1 run_ready in reset", run_ready, 0);
    check("R1 cpu clk in reset", cpu_clk_en, 0);
    check("R1 periph clk in reset", periph_clk_en, TBT_ONLY);
    check("R1 standby in reset", standby_active, 0);
    ctrl_wr = 0; ctrl_wdata = 0; warmup_done = 0;
    rst_n = 1'b1;
    step(4);
    check("R1 held in warm-up", run_ready, 0);
  endtask

  task automatic test_warmup_R2();
    warmup_done = 1'b1;
    step(1);
    warmup_done = 1'b0;
    check("R2 run_ready", run_ready, 1);
    check("R2 cpu clk", cpu_clk_en, 1);
    check("R2 periph clk", periph_clk_en, ALL_ON);
  endtask

  task automatic test_ignore_R10();
    write_ctrl(2'b10);
    check("R10 stays run", run_ready, 1);
    check("R10 bit stays 0", standby_bit, 0);
  endtask

  task automatic test_light_release_R6();
    int_enable = 8'h0F;
    write_ctrl(2'b01);
    check("R3 bit set", standby_bit, 1);
    check("R3 cpu clk off", cpu_clk_en, 0);
    check("R3 not deep", standby_deep, 0);
    check("R9 light clocks", periph_clk_en, ALL_ON);
    int_latch = 8'hF0;
    step(2);
    check("R6 disabled latch ignored", standby_active, 1);
    master_ie = 1'b0;
    int_latch = 8'hF4;
    step(1);
    check("R6 released", standby_active, 0);
    check("R7 bit cleared", standby_bit, 0);
    check("R7 run restored", {run_ready, cpu_clk_en}, 2'b11);
    check("R8 pulse", resume_pulse, 1);
    check("R8 service 0", resume_service, 0);
    int_latch = '0;
    step(1);
    check("R8 pulse one cycle", resume_pulse, 0);
  endtask

  task automatic test_deep_release_R9();
    write_ctrl(2'b11);
    check("R3 deep flag", standby_deep, 1);
    check("R9 deep clocks", periph_clk_en, TBT_ONLY);
    master_ie = 1'b1;
    int_latch = 8'h01;
    step(1);
    check("R8 pulse deep", resume_pulse, 1);
    check("R8 service 1", resume_service, 1);
    check("R7 clocks back", periph_clk_en, ALL_ON);
    int_latch = '0; master_ie = 0;
    step(1);
  endtask

  task automatic test_refuse_R4();
    int_latch = 8'h02;
    write_ctrl(2'b01);
    check("R4 refused", standby_bit, 0);
    check("R4 still run", run_ready, 1);
    int_latch = '0;
    step(1);
  endtask

  task automatic test_wdt_R5();
    wdt_irq = 1'b1; ctrl_wr = 1'b1; ctrl_wdata = 2'b01;
    step(1);
    wdt_irq = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = 2'b00;
    check("R5 same-cycle refused", standby_bit, 0);
    wdt_irq = 1'b1;
    step(1);
    wdt_irq = 1'b0;
    step(WDT_GUARD - 1);
    write_ctrl(2'b01);
    check("R5 inside guard refused", standby_bit, 0);
    step(2);
    write_ctrl(2'b01);
    check("R5 after guard accepted", standby_bit, 1);
  endtask

  task automatic test_sysreset_R1();
    int_latch = 8'h01; sys_reset_req = 1'b1;
    step(1);
    check("R1 sysreset over wake", {standby_active, run_ready, resume_pulse}, 3'b000);
    check("R1 sysreset clocks", periph_clk_en, TBT_ONLY);
    sys_reset_req = 1'b0; int_latch = '0;
    step(1);
    check("R1 stays warm-up", run_ready, 0);
    test_warmup_R2();
  endtask

  initial begin
    test_reset_R1();
    test_warmup_R2();
    test_ignore_R10();
    test_light_release_R6();
    test_deep_release_R9();
    test_refuse_R4();
    test_wdt_R5();
    test_sysreset_R1();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule